// File: doc/BRIEF.md
# Conversion Result and Event Manager

This block sits between a converter's sequencer and the rest of the chip. It keeps the most recent regular conversion result in one data register. Injected conversion results go to a separate data register for each injected rank. It tracks when the regular result has been consumed and raises a result-waiting request for a DMA engine. Nine event sources are gathered into sticky flags, and the flags that are enabled are combined into one interrupt line.

When the unread-result hold is switched on, the block tells the sequencer to hold back the next conversion until the current regular result has been read. When the hold is off, a regular result that arrives before the previous one was read is an overrun. A configuration input decides whether an overrun keeps the old result or replaces it with the new one.

Top module: `conv_result_mgr`

## Requirements
- R1: A regular conversion end (`conv_done_i`=1, `conv_inj_i`=0) that is not an overrun loads `result_i` into `reg_data_o`, and the new value is visible after the next rising clock edge.
- R2: An injected conversion end (`conv_done_i`=1, `conv_inj_i`=1) writes `result_i` into the injected slot chosen by `inj_rank_i`. Slot k sits at `inj_data_o[16k+15:16k]`. The other slots and `reg_data_o` do not change.
- R3: A regular conversion end while a regular result is still unread, with no read strobe in the same cycle, sets the overrun flag. A read in the same cycle as the conversion end consumes the old result, and in that case there is no overrun.
- R4: On an overrun, `reg_data_o` keeps the old value when `ovr_replace_i`=0. It takes the new value when `ovr_replace_i`=1.
- R5: `hold_conv_o` is high exactly while a regular result is unread and `hold_en_i`=1. It drops after the edge on which the read strobe is sampled.
- R6: A read strobe (`rd_data_i`) marks the regular result as consumed and clears the end-of-conversion flag, unless a new regular conversion end arrives in the same cycle.
- R7: `dma_req_o` is high while a regular result is unread and `dma_en_i`=1. It is low otherwise.
- R8: The `flags_o` bit positions are fixed: 0 ready, 1 end of sampling, 2 end of conversion, 3 end of sequence, 4 overrun, 5 injected end of conversion, 6 injected end of sequence, 7 watchdog, 8 injected queue overflow. Each flag is set by its event strobe and stays set until it is cleared.
- R9: Writing a 1 to a bit of `flag_clr_i` clears that flag at the next edge. If the same flag is set and cleared in one cycle, the set wins.
- R10: `irq_o` is the OR, taken over all nine bits, of `flags_o` ANDed with `irq_en_i`. It follows changes of `irq_en_i` in the same cycle.
- R11: `seq_done_i` sets flag 3 when `conv_inj_i`=0 and flag 6 when `conv_inj_i`=1.
- R12: After reset, all flags, `irq_o`, `dma_req_o`, `hold_conv_o`, `reg_data_o` and `inj_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done_i | input | 1 | End-of-conversion strobe |
| conv_inj_i | input | 1 | Channel type of the current strobes: 1 = injected |
| inj_rank_i | input | 2 | Injected rank of the current result |
| result_i | input | 16 | Conversion result |
| seq_done_i | input | 1 | End-of-sequence strobe |
| smp_done_i | input | 1 | End-of-sampling strobe |
| ready_ev_i | input | 1 | Converter-ready event strobe |
| wdog_ev_i | input | 1 | Threshold watchdog event strobe |
| qovf_ev_i | input | 1 | Injected queue overflow strobe |
| rd_data_i | input | 1 | Read strobe of the regular data register |
| ovr_replace_i | input | 1 | 1: an overrun overwrites the held result |
| hold_en_i | input | 1 | Enables the unread-result hold |
| dma_en_i | input | 1 | Enables DMA requests |
| irq_en_i | input | 9 | Interrupt enable for each flag |
| flag_clr_i | input | 9 | Write-one-to-clear for each flag |
| reg_data_o | output | 16 | Regular data register |
| inj_data_o | output | 64 | Four injected data registers |
| flags_o | output | 9 | Sticky event flags |
| irq_o | output | 1 | Combined interrupt |
| dma_req_o | output | 1 | DMA request |
| hold_conv_o | output | 1 | Hold request to the sequencer |

## Verification
Two pairs of events can collide in the same cycle. The first is a regular conversion end landing on the cycle of a read strobe. The bench drives both strobes on one clock and expects the new result, no overrun, the end-of-conversion flag still set and the hold still raised. The second is an event strobe meeting its own write-one-to-clear. The bench drives both together and expects the flag to stay set, then clears it alone and expects it to fall.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int NUM_EV   = 9;
  localparam int EV_RDY   = 0;
  localparam int EV_SMP   = 1;
  localparam int EV_EOC   = 2;
  localparam int EV_EOS   = 3;
  localparam int EV_OVR   = 4;
  localparam int EV_JEOC  = 5;
  localparam int EV_JEOS  = 6;
  localparam int EV_WDOG  = 7;
  localparam int EV_QOVF  = 8;

  // sticky update: set takes priority over clear
  function automatic logic [NUM_EV-1:0] flag_next(input logic [NUM_EV-1:0] cur,
                                                  input logic [NUM_EV-1:0] set,
                                                  input logic [NUM_EV-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_merge(input logic [NUM_EV-1:0] flags,
                                     input logic [NUM_EV-1:0] en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/rm_event_decode.sv
module rm_event_decode
  import rm_pkg::*;
(
  input  logic              conv_done_i,
  input  logic              conv_inj_i,
  input  logic              seq_done_i,
  input  logic              smp_done_i,
  input  logic              ready_ev_i,
  input  logic              wdog_ev_i,
  input  logic              qovf_ev_i,
  input  logic              rd_data_i,
  input  logic              ovr_replace_i,
  input  logic              unread_i,
  output logic [NUM_EV-1:0] set_o,
  output logic              reg_end_o,
  output logic              inj_end_o,
  output logic              ovr_o,
  output logic              load_o
);
  always_comb begin
    reg_end_o = conv_done_i & ~conv_inj_i;
    inj_end_o = conv_done_i &  conv_inj_i;
    // a read in the same cycle consumes the old result first
    ovr_o     = reg_end_o & unread_i & ~rd_data_i;
    load_o    = reg_end_o & (~ovr_o | ovr_replace_i);

    set_o          = '0;
    set_o[EV_RDY]  = ready_ev_i;
    set_o[EV_SMP]  = smp_done_i;
    set_o[EV_EOC]  = reg_end_o;
    set_o[EV_EOS]  = seq_done_i & ~conv_inj_i;
    set_o[EV_OVR]  = ovr_o;
    set_o[EV_JEOC] = inj_end_o;
    set_o[EV_JEOS] = seq_done_i & conv_inj_i;
    set_o[EV_WDOG] = wdog_ev_i;
    set_o[EV_QOVF] = qovf_ev_i;
  end
endmodule

// File: rtl/rm_data_store.sv
module rm_data_store #(
  parameter int DW   = 16,
  parameter int NINJ = 4,
  localparam int RW  = (NINJ > 1) ? $clog2(NINJ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               inj_wr_i,
  input  logic [RW-1:0]      rank_i,
  input  logic [DW-1:0]      data_i,
  input  logic               rd_i,
  output logic [DW-1:0]      reg_data_o,
  output logic               unread_o,
  output logic [NINJ*DW-1:0] inj_data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_data_o <= '0;
      unread_o   <= 1'b0;
    end else begin
      if (load_i) reg_data_o <= data_i;
      if (load_i)    unread_o <= 1'b1;
      else if (rd_i) unread_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < NINJ; g++) begin : g_inj
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inj_data_o[g*DW +: DW] <= '0;
      else if (inj_wr_i && rank_i == RW'(g)) inj_data_o[g*DW +: DW] <= data_i;
    end
  end
endmodule

// File: rtl/rm_flag_bank.sv
module rm_flag_bank
  import rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] set_i,
  input  logic [NUM_EV-1:0] clr_i,
  output logic [NUM_EV-1:0] flags_o
);
  logic [NUM_EV-1:0] nxt;
  assign nxt = flag_next(flags_o, set_i, clr_i);

  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o[g] <= 1'b0;
      else        flags_o[g] <= nxt[g];
    end
  end
endmodule

// File: rtl/conv_result_mgr.sv
module conv_result_mgr
  import rm_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NINJ = 4,
  localparam int RW  = (NINJ > 1) ? $clog2(NINJ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_done_i,
  input  logic               conv_inj_i,
  input  logic [RW-1:0]      inj_rank_i,
  input  logic [DW-1:0]      result_i,
  input  logic               seq_done_i,
  input  logic               smp_done_i,
  input  logic               ready_ev_i,
  input  logic               wdog_ev_i,
  input  logic               qovf_ev_i,
  input  logic               rd_data_i,
  input  logic               ovr_replace_i,
  input  logic               hold_en_i,
  input  logic               dma_en_i,
  input  logic [NUM_EV-1:0]  irq_en_i,
  input  logic [NUM_EV-1:0]  flag_clr_i,
  output logic [DW-1:0]      reg_data_o,
  output logic [NINJ*DW-1:0] inj_data_o,
  output logic [NUM_EV-1:0]  flags_o,
  output logic               irq_o,
  output logic               dma_req_o,
  output logic               hold_conv_o
);
  // named internal events, visible to the bound checker
  logic              unread_q;
  logic              reg_end_w;
  logic              inj_end_w;
  logic              ovr_ev_w;
  logic              load_w;
  logic [NUM_EV-1:0] set_w;
  logic [NUM_EV-1:0] clr_w;

  rm_event_decode u_dec (
    .conv_done_i  (conv_done_i),
    .conv_inj_i   (conv_inj_i),
    .seq_done_i   (seq_done_i),
    .smp_done_i   (smp_done_i),
    .ready_ev_i   (ready_ev_i),
    .wdog_ev_i    (wdog_ev_i),
    .qovf_ev_i    (qovf_ev_i),
    .rd_data_i    (rd_data_i),
    .ovr_replace_i(ovr_replace_i),
    .unread_i     (unread_q),
    .set_o        (set_w),
    .reg_end_o    (reg_end_w),
    .inj_end_o    (inj_end_w),
    .ovr_o        (ovr_ev_w),
    .load_o       (load_w)
  );

  rm_data_store #(.DW(DW), .NINJ(NINJ)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_w),
    .inj_wr_i  (inj_end_w),
    .rank_i    (inj_rank_i),
    .data_i    (result_i),
    .rd_i      (rd_data_i),
    .reg_data_o(reg_data_o),
    .unread_o  (unread_q),
    .inj_data_o(inj_data_o)
  );

  // a read of the regular register acts as a clear of the end-of-conversion flag
  always_comb begin
    clr_w         = flag_clr_i;
    clr_w[EV_EOC] = flag_clr_i[EV_EOC] | rd_data_i;
  end

  rm_flag_bank u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_w),
    .clr_i  (clr_w),
    .flags_o(flags_o)
  );

  assign irq_o       = irq_merge(flags_o, irq_en_i);
  assign dma_req_o   = unread_q & dma_en_i;
  assign hold_conv_o = unread_q & hold_en_i;
endmodule

// File: rtl/rm_checker.sv
module rm_checker
  import rm_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NINJ = 4,
  localparam int RW  = (NINJ > 1) ? $clog2(NINJ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               conv_done_i,
  input logic               conv_inj_i,
  input logic [RW-1:0]      inj_rank_i,
  input logic [DW-1:0]      result_i,
  input logic               ready_ev_i,
  input logic               wdog_ev_i,
  input logic               rd_data_i,
  input logic               ovr_replace_i,
  input logic               hold_en_i,
  input logic [NUM_EV-1:0]  flag_clr_i,
  input logic [DW-1:0]      reg_data_o,
  input logic [NINJ*DW-1:0] inj_data_o,
  input logic [NUM_EV-1:0]  flags_o,
  input logic               hold_conv_o,
  input logic               ovr_ev_w,
  input logic               load_w
);
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> reg_data_o == $past(result_i));

  for (genvar g = 0; g < NINJ; g++) begin : g_inj_chk
    p_inj_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && conv_inj_i && inj_rank_i == RW'(g))
      |=> inj_data_o[g*DW +: DW] == $past(result_i));
  end

  p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en_i && hold_conv_o && conv_done_i && !conv_inj_i && !rd_data_i)
    |=> flags_o[EV_OVR]);

  p_keep_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ev_w && !ovr_replace_i) |=> $stable(reg_data_o));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !(conv_done_i && !conv_inj_i) && hold_en_i) |=> !hold_conv_o);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !(conv_done_i && !conv_inj_i)) |=> !flags_o[EV_EOC]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[EV_WDOG] && !flag_clr_i[EV_WDOG]) |=> flags_o[EV_WDOG]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_ev_i && flag_clr_i[EV_RDY]) |=> flags_o[EV_RDY]);

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i[EV_WDOG] && !wdog_ev_i) |=> !flags_o[EV_WDOG]);

  p_no_load_on_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev_w |-> (load_w == ovr_replace_i));
endmodule

bind conv_result_mgr rm_checker #(.DW(DW), .NINJ(NINJ)) u_chk (.*);

// File: tb/sim_conv_result_mgr.sv
module sim_conv_result_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done_i = 0, conv_inj_i = 0, seq_done_i = 0, smp_done_i = 0;
  logic [1:0]  inj_rank_i = 0;
  logic [15:0] result_i = 0;
  logic        ready_ev_i = 0, wdog_ev_i = 0, qovf_ev_i = 0, rd_data_i = 0;
  logic        ovr_replace_i = 0, hold_en_i = 0, dma_en_i = 0;
  logic [8:0]  irq_en_i = 0, flag_clr_i = 0;
  logic [15:0] reg_data_o;
  logic [63:0] inj_data_o;
  logic [8:0]  flags_o;
  logic        irq_o, dma_req_o, hold_conv_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  conv_result_mgr u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic conv(input logic inj, input logic [1:0] rank, input logic [15:0] d, input logic rd);
    conv_done_i = 1; conv_inj_i = inj; inj_rank_i = rank; result_i = d; rd_data_i = rd;
    cyc();
    conv_done_i = 0; conv_inj_i = 0; rd_data_i = 0;
  endtask

  task automatic do_read();
    rd_data_i = 1; cyc(); rd_data_i = 0;
  endtask

  task automatic wipe();
    do_read();
    flag_clr_i = '1; cyc(); flag_clr_i = '0;
  endtask

  task automatic t_reset();
    chk("R12 flags", flags_o, 0);
    chk("R12 irq", irq_o, 0);
    chk("R12 dma", dma_req_o, 0);
    chk("R12 hold", hold_conv_o, 0);
    chk("R12 data", reg_data_o, 0);
    chk("R12 inj", inj_data_o, 0);
  endtask

  task automatic t_regular();
    hold_en_i = 1; dma_en_i = 1; irq_en_i = 9'h004;
    conv(0, 0, 16'hA5A5, 0);
    chk("R1 data", reg_data_o, 16'hA5A5);
    chk("R8 eoc flag bit2", flags_o[2], 1);
    chk("R5 hold raised", hold_conv_o, 1);
    chk("R7 dma raised", dma_req_o, 1);
    chk("R10 irq enabled", irq_o, 1);
    irq_en_i = 9'h1FB; #1;
    chk("R10 irq masked", irq_o, 0);
    irq_en_i = 0;
    do_read();
    chk("R5 hold released", hold_conv_o, 0);
    chk("R6 eoc cleared", flags_o[2], 0);
    chk("R7 dma dropped", dma_req_o, 0);
    chk("R6 data kept", reg_data_o, 16'hA5A5);
  endtask

  task automatic t_overrun_keep();
    wipe(); ovr_replace_i = 0;
    conv(0, 0, 16'h1111, 0);
    conv(0, 0, 16'h2222, 0);
    chk("R3 overrun set", flags_o[4], 1);
    chk("R4 old kept", reg_data_o, 16'h1111);
  endtask

  task automatic t_overrun_replace();
    wipe(); ovr_replace_i = 1;
    conv(0, 0, 16'h3333, 0);
    conv(0, 0, 16'h4444, 0);
    chk("R3 overrun set again", flags_o[4], 1);
    chk("R4 replaced", reg_data_o, 16'h4444);
    ovr_replace_i = 0;
  endtask

  task automatic t_same_cycle();
    wipe();
    conv(0, 0, 16'h5555, 0);
    conv(0, 0, 16'h6666, 1);
    chk("R3 no overrun with read", flags_o[4], 0);
    chk("R1 new data", reg_data_o, 16'h6666);
    chk("R6 eoc stays set", flags_o[2], 1);
    chk("R5 hold stays", hold_conv_o, 1);
  endtask

  task automatic t_injected();
    wipe();
    for (int k = 0; k < 4; k++) conv(1, 2'(k), 16'hC000 + 16'(k), 0);
    chk("R2 slots", inj_data_o, 64'hC003_C002_C001_C000);
    chk("R2 reg untouched", reg_data_o, 16'h6666);
    chk("R8 jeoc bit5", flags_o[5], 1);
    chk("R2 no regular eoc", flags_o[2], 0);
    conv_inj_i = 1; seq_done_i = 1; cyc(); seq_done_i = 0; conv_inj_i = 0;
    chk("R11 jeos bit6", flags_o[6], 1);
    chk("R11 eos clear", flags_o[3], 0);
    seq_done_i = 1; cyc(); seq_done_i = 0;
    chk("R11 eos bit3", flags_o[3], 1);
  endtask

  task automatic t_flags();
    wipe();
    ready_ev_i = 1; flag_clr_i = 9'h001; cyc(); ready_ev_i = 0; flag_clr_i = 0;
    chk("R9 set wins", flags_o[0], 1);
    flag_clr_i = 9'h001; cyc(); flag_clr_i = 0;
    chk("R9 w1c", flags_o[0], 0);
    smp_done_i = 1; wdog_ev_i = 1; qovf_ev_i = 1; cyc();
    smp_done_i = 0; wdog_ev_i = 0; qovf_ev_i = 0;
    cyc();
    chk("R8 sticky bits 1,7,8", flags_o, 9'h182);
    irq_en_i = 9'h100; #1;
    chk("R10 irq qovf", irq_o, 1);
    irq_en_i = 0;
  endtask

  task automatic t_hold_off();
    wipe(); hold_en_i = 0; dma_en_i = 0;
    conv(0, 0, 16'h7777, 0);
    chk("R5 no hold when disabled", hold_conv_o, 0);
    chk("R7 no dma when disabled", dma_req_o, 0);
    hold_en_i = 1; #1;
    chk("R5 hold follows enable", hold_conv_o, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_n = 1;
    cyc();
    t_reset();
    t_regular();
    t_overrun_keep();
    t_overrun_replace();
    t_same_cycle();
    t_injected();
    t_flags();
    t_hold_off();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule